// File: doc/BRIEF.md
# Two-Wire Bus-Clear Sequencer

This block frees a two-wire serial bus that a target device is holding stuck, for example with the data line held low partway through a byte. It controls the clock and data lines through open-drain pull-low enables. A pull-low enable that is asserted drives its line low. A pull-low enable that is deasserted leaves the line to the external pull-up. Software can set either enable directly through two override bits in a small control register. The same register also returns the synchronised levels of both lines.

A single-cycle start pulse launches a fixed recovery sequence. The sequencer toggles the clock line nine times so that any target can finish shifting out its byte. It then forms a stop condition: the data line is pulled low, the clock line is released, and finally the data line is released while the clock line is high. Each step of the sequence lasts `PHASE_CYCLES` clock cycles, chosen so that one step is about 5 µs. While the sequence runs, `busy` is high. During that time the sequencer has full control of both lines, so further start pulses and register writes are discarded. When it finishes, the lines go back to whatever the override bits hold.

Top module: `bus_clear_seq`

## Requirements
- R1: After reset, `scl_pull` and `sda_pull` are 0 and `busy` is 0. `ctrl_rdata` reads 16'h0C00: both override bits are 0 and both level bits are 1.
- R2: When idle, a write with `ctrl_we` high stores `ctrl_wdata` bit 8 as the data override and bit 9 as the clock override. From the cycle after the write edge, `sda_pull` and `scl_pull` follow those bits, and the bits read back at the same positions in `ctrl_rdata`.
- R3: A start pulse seen while idle sets `busy` from the next cycle. `busy` then stays high for exactly (2·PULSES+2)·PHASE_CYCLES cycles.
- R4: The sequence opens with PULSES clock pulses, nine by default. Each pulse is `scl_pull` at 0 for PHASE_CYCLES cycles followed by `scl_pull` at 1 for PHASE_CYCLES cycles. `sda_pull` stays 0 for the whole pulse train.
- R5: After the pulses, `sda_pull` is 1 with `scl_pull` at 1 for one phase. Next, `scl_pull` is 0 with `sda_pull` still 1 for one phase. Then both drop to 0 in the cycle in which `busy` falls, which forms a stop condition.
- R6: A start pulse while `busy` is high is ignored. The sequence timing and its end cycle do not change.
- R7: A register write while `busy` is high is ignored. The override bits keep their earlier values.
- R8: `ctrl_rdata` bit 10 holds the level of `sda_in` and bit 11 holds the level of `scl_in`, each through SYNC_STAGES flops. With the default of 2, a change is visible after the second clock edge that follows it. All other read bits are 0.
- R9: When the sequence ends, `scl_pull` and `sda_pull` follow the override bits again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Single-cycle request to run the recovery sequence |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | REG_W | Write data; bit 8 data override, bit 9 clock override |
| ctrl_rdata | output | REG_W | Override bits 8/9, synchronised data level bit 10, clock level bit 11 |
| scl_in | input | 1 | Clock line level as seen at the pad |
| sda_in | input | 1 | Data line level as seen at the pad |
| scl_pull | output | 1 | Pull clock line low when 1 |
| sda_pull | output | 1 | Pull data line low when 1 |
| busy | output | 1 | Recovery sequence in progress |

## Verification
A wrong phase index or counter value shows directly on the pull-low enables. A miscounted phase moves a clock edge by whole cycles, and a wrong index gives a pulse pattern that breaks the fixed template. Both appear in the very first phase where the state diverges, and the bench compares every cycle of the sequence against the template. A corrupted busy flag or override register shows at the pins in the following cycle, because it changes the sequence length or leaves the lines stuck once the sequence ends. Discarded starts and writes are confirmed by the unchanged end cycle and by the override bits read back afterwards.

// File: rtl/bc_pkg.sv
`timescale 1ns/1ps
package bc_pkg;
  // Register bit positions; software decodes these.
  localparam int SDA_OVR_BIT = 8;
  localparam int SCL_OVR_BIT = 9;
  localparam int SDA_LVL_BIT = 10;
  localparam int SCL_LVL_BIT = 11;

  typedef struct packed {
    logic scl;
    logic sda;
  } line_pair_t;
endpackage

// File: rtl/bc_phase_timer.sv
`timescale 1ns/1ps
module bc_phase_timer #(
  parameter int PHASE_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PHASE_CYCLES - 1);

  logic [CNT_W-1:0] count;

  assign tick = run && (count == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (!run || count == LAST) begin
      count <= '0;
    end else begin
      count <= count + 1'b1;
    end
  end

  p_count_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= LAST);
  p_idle_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> count == '0);
endmodule

// File: rtl/bc_line_sync.sv
`timescale 1ns/1ps
module bc_line_sync import bc_pkg::*; #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  line_pair_t raw,
  output line_pair_t synced
);
  line_pair_t stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage[s] <= '{scl: 1'b1, sda: 1'b1};
        end else if (s == 0) begin
          stage[s] <= raw;
        end else begin
          stage[s] <= stage[(s == 0) ? 0 : s - 1];
        end
      end
    end
  endgenerate

  assign synced = stage[STAGES-1];
endmodule

// File: rtl/bc_step_seq.sv
`timescale 1ns/1ps
module bc_step_seq import bc_pkg::*; #(
  parameter int PULSES = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       tick,
  output logic       busy,
  output line_pair_t drive
);
  localparam int N_PHASES = 2 * PULSES + 2;
  localparam int IDX_W    = $clog2(N_PHASES);
  localparam logic [IDX_W-1:0] LAST      = IDX_W'(N_PHASES - 1);
  localparam logic [IDX_W-1:0] PULSE_END = IDX_W'(2 * PULSES);

  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        idx  <= '0;
      end
    end else if (tick) begin
      if (idx == LAST) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  // Pulse train: even phase released, odd phase pulled.
  // Then data pulled with clock pulled, then clock released with data held.
  always_comb begin
    drive = '0;
    if (busy) begin
      if (idx < PULSE_END) begin
        drive.scl = idx[0];
      end else if (idx == PULSE_END) begin
        drive.scl = 1'b1;
        drive.sda = 1'b1;
      end else begin
        drive.sda = 1'b1;
      end
    end
  end

  p_start_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start |=> busy && idx == '0);
  p_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !tick |=> busy && $stable(idx));
endmodule

// File: rtl/bc_ctrl_reg.sv
`timescale 1ns/1ps
module bc_ctrl_reg import bc_pkg::*; #(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  input  logic             lock,
  input  line_pair_t       level,
  output line_pair_t       manual,
  output logic [REG_W-1:0] rdata
);
  logic unused_wbits;
  assign unused_wbits = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      manual <= '0;
    end else if (we && !lock) begin
      manual.scl <= wdata[SCL_OVR_BIT];
      manual.sda <= wdata[SDA_OVR_BIT];
    end
  end

  always_comb begin
    rdata = '0;
    rdata[SDA_OVR_BIT] = manual.sda;
    rdata[SCL_OVR_BIT] = manual.scl;
    rdata[SDA_LVL_BIT] = level.sda;
    rdata[SCL_LVL_BIT] = level.scl;
  end

  p_write_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lock && we |=> $stable(manual));
endmodule

// File: rtl/bus_clear_seq.sv
`timescale 1ns/1ps
module bus_clear_seq import bc_pkg::*; #(
  parameter int PHASE_CYCLES = 1000,
  parameter int PULSES       = 9,
  parameter int SYNC_STAGES  = 2,
  parameter int REG_W        = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             ctrl_we,
  input  logic [REG_W-1:0] ctrl_wdata,
  output logic [REG_W-1:0] ctrl_rdata,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_pull,
  output logic             sda_pull,
  output logic             busy
);
  line_pair_t raw_lvl, lvl, manual, seq_drive;
  logic       tick;

  assign raw_lvl = '{scl: scl_in, sda: sda_in};

  bc_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(raw_lvl), .synced(lvl)
  );

  bc_phase_timer #(.PHASE_CYCLES(PHASE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
  );

  bc_step_seq #(.PULSES(PULSES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .tick(tick),
    .busy(busy), .drive(seq_drive)
  );

  bc_ctrl_reg #(.REG_W(REG_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .we(ctrl_we), .wdata(ctrl_wdata),
    .lock(busy), .level(lvl), .manual(manual), .rdata(ctrl_rdata)
  );

  assign scl_pull = busy ? seq_drive.scl : manual.scl;
  assign sda_pull = busy ? seq_drive.sda : manual.sda;

  // Stop condition: data held low, clock released, just before the end.
  p_stop_form_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(sda_pull) && !$past(scl_pull));
endmodule

// File: tb/tb_bus_clear_seq.sv
`timescale 1ns/1ps
module tb_bus_clear_seq;
  localparam int P      = 4;
  localparam int PULSES = 9;
  localparam int NPH    = 2 * PULSES + 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [15:0] ctrl_wdata = '0;
  logic [15:0] ctrl_rdata;
  logic        scl_pull, sda_pull, busy;
  logic        ext_scl_low = 1'b0, ext_sda_low = 1'b0;
  logic        scl_in, sda_in;
  int          checks = 0;
  int          errors = 0;

  assign scl_in = ~(scl_pull | ext_scl_low);
  assign sda_in = ~(sda_pull | ext_sda_low);

  always #2.5 clk = ~clk;

  bus_clear_seq #(.PHASE_CYCLES(P), .PULSES(PULSES), .SYNC_STAGES(2), .REG_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ctrl_we(ctrl_we),
    .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata), .scl_in(scl_in),
    .sda_in(sda_in), .scl_pull(scl_pull), .sda_pull(sda_pull), .busy(busy)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic write_reg(input logic [15:0] d);
    ctrl_we = 1'b1; ctrl_wdata = d;
    step();
    ctrl_we = 1'b0; ctrl_wdata = '0;
  endtask

  task automatic t_reset();
    chk("R1", "scl_pull", scl_pull, 0);
    chk("R1", "sda_pull", sda_pull, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "rdata", ctrl_rdata, 32'h0C00);
  endtask

  task automatic t_manual();
    write_reg(16'h0200);
    chk("R2", "scl_pull after write", scl_pull, 1);
    chk("R2", "sda_pull after write", sda_pull, 0);
    chk("R2", "rdata ovr bits", ctrl_rdata[9:8], 2'b10);
    write_reg(16'h0100);
    chk("R2", "scl_pull second", scl_pull, 0);
    chk("R2", "sda_pull second", sda_pull, 1);
    write_reg(16'h0000);
    chk("R2", "cleared", {scl_pull, sda_pull}, 0);
  endtask

  task automatic t_levels();
    step(); step();
    ext_sda_low = 1'b1;
    step();
    chk("R8", "sda level after one edge", ctrl_rdata[10], 1);
    step();
    chk("R8", "sda level after two edges", ctrl_rdata[10], 0);
    chk("R8", "scl level unchanged", ctrl_rdata[11], 1);
    ext_sda_low = 1'b0; ext_scl_low = 1'b1;
    step(); step();
    chk("R8", "scl level low", ctrl_rdata[11:10], 2'b01);
    chk("R8", "other bits zero", {ctrl_rdata[15:12], ctrl_rdata[7:0]}, 0);
    ext_scl_low = 1'b0;
    step(); step();
  endtask

  // Run the full recovery sequence and compare each cycle with the template.
  task automatic t_sequence(input bit poke, input logic [1:0] man_exp);
    int bad;
    int scl_rises;
    logic prev_scl;
    bad = 0; scl_rises = 0; prev_scl = 1'b0;
    start = 1'b1;
    step();
    start = 1'b0;
    chk("R3", "busy after start", busy, 1);
    for (int s = 0; s < NPH * P; s++) begin
      int ph;
      logic es, ed;
      ph = s / P;
      es = (ph < 2 * PULSES) ? ph[0] : (ph == 2 * PULSES);
      ed = (ph >= 2 * PULSES);
      if (busy !== 1'b1 || scl_pull !== es || sda_pull !== ed) begin
        bad++;
        if (bad == 1)
          $display("FAIL R4/R5 step %0d: busy %b scl %b sda %b expected 1 %b %b",
                   s, busy, scl_pull, sda_pull, es, ed);
      end
      if (ph < 2 * PULSES && prev_scl && !scl_pull) scl_rises++;
      prev_scl = scl_pull;
      if (poke && s == 5) begin
        start = 1'b1; ctrl_we = 1'b1; ctrl_wdata = 16'h0300;
      end
      step();
      start = 1'b0; ctrl_we = 1'b0; ctrl_wdata = '0;
    end
    checks++;
    if (bad != 0) errors++;
    // releases after a pulled phase inside the pulse train: PULSES-1 (last pull ends at stop phase)
    chk("R4", "clock releases within pulse train", scl_rises, PULSES - 1);
    chk("R3", "busy end", busy, 0);
    chk("R5", "both released at end", {scl_pull, sda_pull}, man_exp);
    if (poke) begin
      chk("R6", "no restart after busy", busy, 0);
      chk("R7", "override bits kept", ctrl_rdata[9:8], {man_exp[1], man_exp[0]});
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1;
    step(); step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_manual();
    t_levels();
    t_sequence(1'b0, 2'b00);
    write_reg(16'h0100);
    t_sequence(1'b1, 2'b01);
    chk("R9", "sda_pull follows override", sda_pull, 1);
    chk("R9", "scl_pull follows override", scl_pull, 0);
    write_reg(16'h0000);
    chk("R9", "release after clear", {scl_pull, sda_pull}, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule